// File: doc/BRIEF.md
# Configuration Register Integrity Monitor

This block guards a bank of configuration and control bytes in a safety-critical driver. When the device is in its active operating state and integrity checking is enabled, the block walks the protected bytes one per clock. It folds them into an 8-bit CRC and keeps the result as the reference. From then on a timer starts a fresh pass over the same bytes at a fixed period, and the block compares each new result with the reference.

A mismatch sets a sticky status flag and requests a forced safe output state. The code of that safe state comes from a configuration field. Unless the fault is masked, the mismatch also pulls an active-low fault pin. A self-test command corrupts the next comparison on purpose, so that software can prove the detection path works. Leaving the active state, or clearing the enable, stops the checking. It also throws away the reference and any pending self-test.

Top module: `cfg_crc_watch`

## Requirements
- R1: The reference is an 8-bit CRC with generator 0x07 (x^8+x^2+x+1) and start value 0xFF, taken MSB first, with no reflection and no final XOR. Bytes are folded in ascending address order, and byte i sits at `regBank[8i+7:8i]`. A bank left unchanged therefore never reports a mismatch against its own reference.
- R2: Call S the first rising edge at which `isActive` and `crcEnable` are both high. The k-th comparison (k >= 1) finishes at edge S + 2*NUM_REGS + k*PERIOD_CYC, and a mismatch there makes `crcFault` high right after that edge.
- R3: While the protected bytes stay equal to their values during the reference pass, `crcFault` never rises.
- R4: A change to any single protected byte, first or last address included, is reported by the next comparison. The reference is not recomputed while checking runs, so the mismatch repeats at every later comparison.
- R5: `crcFault` is sticky. A high `statusClear` at an edge clears it, except when a mismatch is found at that same edge; in that case the set wins.
- R6: `faultN` is low exactly when `crcFault` is high and `faultMask` is low. The mask has no effect on `crcFault`.
- R7: `safeReq` equals `crcFault`. While it is high, `safeCode` equals `safeSel`; otherwise `safeCode` is zero.
- R8: A high `injectCmd` at an edge while checking runs arms a single inversion of bit 0 of the next computed CRC before it is compared. That comparison therefore reports a mismatch, and the following one does not.
- R9: When `isActive` or `crcEnable` goes low, the block performs no comparison, and it discards the reference and any armed injection. When both are high again, the block computes a fresh reference.
- R10: After reset, `crcFault`, `safeReq` and `safeCode` are zero and `faultN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regBank | input | NUM_REGS*8 | Protected bytes, byte i at bits 8i+7:8i |
| isActive | input | 1 | Device is in its active operating state |
| crcEnable | input | 1 | Configuration-CRC checking enable |
| faultMask | input | 1 | Masks the fault pin when high |
| injectCmd | input | 1 | Arms one deliberate CRC corruption |
| statusClear | input | 1 | Write-one-to-clear of the status flag |
| safeSel | input | SAFE_W | Selected forced output state |
| crcFault | output | 1 | Sticky mismatch status |
| faultN | output | 1 | Active-low fault pin |
| safeReq | output | 1 | Request to force the safe output state |
| safeCode | output | SAFE_W | Safe state code while requested, else zero |

## Verification
The two functions that can collide are a mismatch found at the end of a comparison pass and a software write-one-to-clear of the sticky flag. The bench arms an injected error and then holds `statusClear` high in exactly the cycle whose edge completes the next comparison. That cycle is computed from the R2 timing. The bench judges the collision by the flag and the fault pin after that edge: the flag must be set and the pin low.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;

  // Strobes sent from the sequencer to the CRC datapath
  typedef struct packed {
    logic init;     // restart accumulator and byte pointer
    logic step;     // fold current byte into accumulator
    logic capRef;   // store the finished CRC as reference
    logic compare;  // compare the finished CRC with reference
    logic drop;     // discard the reference
  } crcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REF,
    ST_WAIT,
    ST_CHK
  } crcState_t;

  // One byte of CRC-8, generator 0x07, MSB first
  function automatic logic [7:0] crc8Byte(input logic [7:0] crcIn,
                                          input logic [7:0] dataIn);
    logic [7:0] r;
    r = crcIn ^ dataIn;
    for (int b = 0; b < 8; b++) begin
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_crc_dp.sv
module cfg_crc_dp
  import cfg_crc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_REGS*8-1:0] regBank,
  input  crcStrobe_t            strobe,
  input  logic                  injFlip,
  output logic                  lastByte,
  output logic                  mismatch
);

  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       crcAcc;
  logic [7:0]       refCrc;
  logic [7:0]       curByte;
  logic [7:0]       crcNext;

  assign curByte  = regBank[8*int'(byteIdx) +: 8];
  assign crcNext  = crc8Byte(crcAcc, curByte);
  assign lastByte = (byteIdx == IDX_W'(NUM_REGS - 1));
  assign mismatch = strobe.compare &&
                    ((crcNext ^ {7'b0, injFlip}) != refCrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      crcAcc  <= 8'hFF;
    end else if (strobe.init) begin
      byteIdx <= '0;
      crcAcc  <= 8'hFF;
    end else if (strobe.step) begin
      crcAcc  <= crcNext;
      byteIdx <= lastByte ? '0 : byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCrc <= '0;
    end else if (strobe.drop) begin
      refCrc <= '0;
    end else if (strobe.capRef) begin
      refCrc <= crcNext;
    end
  end

endmodule

// File: rtl/cfg_crc_ctrl.sv
module cfg_crc_ctrl
  import cfg_crc_pkg::*;
#(
  parameter int PERIOD_CYC = 40,
  parameter int TMR_W      = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runOk,
  input  logic       lastByte,
  input  logic       mismatch,
  input  logic       injectCmd,
  input  logic       statusClear,
  output crcStrobe_t strobe,
  output logic       injFlip,
  output logic       statusQ,
  output logic       busy
);

  crcState_t        state;
  logic [TMR_W-1:0] timer;
  logic             injArm;
  logic             periodHit;

  assign periodHit = (timer == TMR_W'(PERIOD_CYC - 1));
  assign injFlip   = injArm;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    if (!runOk) begin
      strobe.drop = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: strobe.init = 1'b1;
        ST_REF: begin
          strobe.step   = 1'b1;
          strobe.capRef = lastByte;
        end
        ST_WAIT: strobe.init = periodHit;
        ST_CHK: begin
          strobe.step    = 1'b1;
          strobe.compare = lastByte;
        end
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (!runOk) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_REF;
        ST_REF: begin
          timer <= '0;
          if (lastByte) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (periodHit) begin
            state <= ST_CHK;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_CHK: begin
          timer <= timer + 1'b1;
          if (lastByte) state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      injArm <= 1'b0;
    end else if (!runOk) begin
      injArm <= 1'b0;
    end else begin
      injArm <= (injArm && !strobe.compare) || injectCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= 1'b0;
    end else if (mismatch) begin
      statusQ <= 1'b1;
    end else if (statusClear) begin
      statusQ <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_crc_watch.sv
module cfg_crc_watch
  import cfg_crc_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int PERIOD_CYC = 40,
  parameter int SAFE_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_REGS*8-1:0] regBank,
  input  logic                  isActive,
  input  logic                  crcEnable,
  input  logic                  faultMask,
  input  logic                  injectCmd,
  input  logic                  statusClear,
  input  logic [SAFE_W-1:0]     safeSel,
  output logic                  crcFault,
  output logic                  faultN,
  output logic                  safeReq,
  output logic [SAFE_W-1:0]     safeCode
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int TMR_W = $clog2(PERIOD_CYC);

  initial begin
    if (PERIOD_CYC <= NUM_REGS + 1)
      $error("PERIOD_CYC must exceed NUM_REGS + 1");
  end

  crcStrobe_t strobe;
  logic       runOk;
  logic       lastByte;
  logic       mismatch;
  logic       injFlip;
  logic       statusQ;
  logic       busy;

  assign runOk = isActive && crcEnable;

  cfg_crc_ctrl #(
    .PERIOD_CYC(PERIOD_CYC),
    .TMR_W     (TMR_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .runOk      (runOk),
    .lastByte   (lastByte),
    .mismatch   (mismatch),
    .injectCmd  (injectCmd),
    .statusClear(statusClear),
    .strobe     (strobe),
    .injFlip    (injFlip),
    .statusQ    (statusQ),
    .busy       (busy)
  );

  cfg_crc_dp #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .regBank (regBank),
    .strobe  (strobe),
    .injFlip (injFlip),
    .lastByte(lastByte),
    .mismatch(mismatch)
  );

  assign crcFault = statusQ;
  assign faultN   = !(statusQ && !faultMask);
  assign safeReq  = statusQ;
  assign safeCode = statusQ ? safeSel : '0;

endmodule

// File: rtl/cfg_crc_watch_chk.sv
module cfg_crc_watch_chk #(
  parameter int SAFE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              isActive,
  input logic              crcEnable,
  input logic              faultMask,
  input logic              statusClear,
  input logic [SAFE_W-1:0] safeSel,
  input logic              crcFault,
  input logic              faultN,
  input logic              safeReq,
  input logic [SAFE_W-1:0] safeCode,
  input logic              busy
);

  // R9: a new fault can only come from a check while running
  p_set_needs_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcFault) |-> $past(isActive && crcEnable));

  // R5: flag holds unless cleared
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    crcFault && !statusClear |=> crcFault);

  // R5: only a clear request can lower the flag
  p_clear_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(crcFault) |-> $past(statusClear));

  // R6: unmasked fault drives the pin low
  p_pin_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    crcFault && !faultMask |-> !faultN);

  // R6: no fault or masked keeps the pin high
  p_pin_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!crcFault || faultMask) |-> faultN);

  // R7: safe code follows the selection while requested
  p_safe_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    safeReq |-> (safeCode == safeSel));

  // R7: no code without a request
  p_safe_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !safeReq |-> (safeCode == '0));

  // R9: stopping returns the sequencer to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(isActive && crcEnable) |=> !busy);

endmodule

bind cfg_crc_watch cfg_crc_watch_chk #(.SAFE_W(SAFE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .isActive   (isActive),
  .crcEnable  (crcEnable),
  .faultMask  (faultMask),
  .statusClear(statusClear),
  .safeSel    (safeSel),
  .crcFault   (crcFault),
  .faultN     (faultN),
  .safeReq    (safeReq),
  .safeCode   (safeCode),
  .busy       (busy)
);

// File: tb/cfg_crc_watch_tb_top.sv
module cfg_crc_watch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 4;
  localparam int PER        = 40;
  localparam int SW         = 2;

  logic            clk = 1'b0;
  logic            rstN;
  logic [NREG*8-1:0] regBank;
  logic            isActive, crcEnable, faultMask, injectCmd, statusClear;
  logic [SW-1:0]   safeSel;
  logic            crcFault, faultN, safeReq;
  logic [SW-1:0]   safeCode;

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;

  typedef struct {
    int          at;
    logic        st;
    logic        fn;
    logic [SW-1:0] sc;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_crc_watch #(.NUM_REGS(NREG), .PERIOD_CYC(PER), .SAFE_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .regBank(regBank), .isActive(isActive),
    .crcEnable(crcEnable), .faultMask(faultMask), .injectCmd(injectCmd),
    .statusClear(statusClear), .safeSel(safeSel), .crcFault(crcFault),
    .faultN(faultN), .safeReq(safeReq), .safeCode(safeCode)
  );

  // Driver side: push an expected output set for a given cycle
  task automatic expectAt(input int at, input logic st, input logic fn,
                          input logic [SW-1:0] sc, input string tag);
    exp_t e;
    e.at = at; e.st = st; e.fn = fn; e.sc = sc; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic waitCyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  // Monitor: compare queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        nChecks++;
        if (e.at < cyc) begin
          nErr++;
          $display("FAIL %s: actual=missed at %0d expected=sample at %0d", e.tag, cyc, e.at);
        end else if (crcFault !== e.st || faultN !== e.fn ||
                     safeReq !== e.st || safeCode !== e.sc) begin
          nErr++;
          $display("FAIL %s @%0d: actual st=%b fn=%b sr=%b sc=%b expected st=%b fn=%b sr=%b sc=%b",
                   e.tag, cyc, crcFault, faultN, safeReq, safeCode,
                   e.st, e.fn, e.st, e.sc);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; regBank = 32'hA53C0F71; isActive = 1'b0; crcEnable = 1'b0;
    faultMask = 1'b0; injectCmd = 1'b0; statusClear = 1'b0; safeSel = 2'b10;
    expectAt(1, 1'b0, 1'b1, 2'b00, "R10 reset state");
    waitCyc(2);  rstN = 1'b1;
    // start running: first edge S=6, compares at 54, 94, 134, ...
    waitCyc(5);  isActive = 1'b1; crcEnable = 1'b1;
    expectAt(55, 1'b0, 1'b1, 2'b00, "R1 R3 unchanged bank matches");
    waitCyc(60); injectCmd = 1'b1;
    expectAt(93, 1'b0, 1'b1, 2'b00, "R2 no fault before compare edge");
    expectAt(94, 1'b1, 1'b0, 2'b10, "R8 R2 R7 injected error flagged");
    waitCyc(61); injectCmd = 1'b0;
    waitCyc(100); faultMask = 1'b1;
    expectAt(100, 1'b1, 1'b1, 2'b10, "R6 mask releases pin, flag kept");
    waitCyc(110); statusClear = 1'b1;
    expectAt(111, 1'b0, 1'b1, 2'b00, "R5 write-one clears flag");
    waitCyc(111); statusClear = 1'b0;
    expectAt(135, 1'b0, 1'b1, 2'b00, "R8 injection is one-shot");
    waitCyc(140); faultMask = 1'b0;
    expectAt(140, 1'b0, 1'b1, 2'b00, "R6 unmasked without fault");
    // change byte 2 during the wait: caught at compare 174
    waitCyc(150); regBank[23:16] = 8'h1E;
    expectAt(173, 1'b0, 1'b1, 2'b00, "R4 not yet compared");
    expectAt(174, 1'b1, 1'b0, 2'b10, "R4 changed byte detected");
    expectAt(178, 1'b1, 1'b0, 2'b10, "R5 flag stays set");
    waitCyc(180); statusClear = 1'b1;
    expectAt(181, 1'b0, 1'b1, 2'b00, "R5 clear");
    waitCyc(181); statusClear = 1'b0;
    expectAt(214, 1'b1, 1'b0, 2'b10, "R4 reference kept, repeats");
    waitCyc(220); statusClear = 1'b1; safeSel = 2'b01;
    expectAt(220, 1'b1, 1'b0, 2'b01, "R7 code follows select");
    expectAt(221, 1'b0, 1'b1, 2'b00, "R5 clear again");
    waitCyc(221); statusClear = 1'b0;
    // leave active: no compare at 254
    waitCyc(222); isActive = 1'b0;
    expectAt(256, 1'b0, 1'b1, 2'b00, "R9 no check while inactive");
    // re-enter: S=261, compares 309, 349
    waitCyc(260); isActive = 1'b1;
    expectAt(310, 1'b0, 1'b1, 2'b00, "R9 fresh reference on re-entry");
    waitCyc(315); injectCmd = 1'b1;
    waitCyc(316); injectCmd = 1'b0;
    waitCyc(348); statusClear = 1'b1;
    expectAt(348, 1'b0, 1'b1, 2'b00, "R5 before collision");
    expectAt(349, 1'b1, 1'b0, 2'b01, "R5 set wins over clear");
    waitCyc(349); statusClear = 1'b0;
    waitCyc(355); statusClear = 1'b1;
    expectAt(356, 1'b0, 1'b1, 2'b00, "R5 clear after collision");
    waitCyc(356); statusClear = 1'b0;
    // disable: bank change and injection must be ignored
    waitCyc(360); crcEnable = 1'b0;
    waitCyc(361); regBank[7:0] = 8'hC4; injectCmd = 1'b1;
    waitCyc(362); injectCmd = 1'b0;
    expectAt(391, 1'b0, 1'b1, 2'b00, "R9 no check while disabled");
    // re-enable: S=401, compares 449, 489
    waitCyc(400); crcEnable = 1'b1;
    expectAt(450, 1'b0, 1'b1, 2'b00, "R9 R8 injection discarded, new reference");
    waitCyc(460); regBank[31:24] = 8'h5A;
    expectAt(488, 1'b0, 1'b1, 2'b00, "R4 last byte before compare");
    expectAt(489, 1'b1, 1'b0, 2'b01, "R4 last-address byte detected");
    waitCyc(495);
    if (sbq.size() != 0) begin
      nChecks++;
      nErr++;
      $display("FAIL R2 scoreboard: actual=%0d pending expected=0", sbq.size());
    end
    report();
    $finish;
  end

endmodule